// File: doc/BRIEF.md
# Usage-Time and Event Recorder Core

This core tracks how long a piece of equipment has been in use and how many separate usage sessions it has seen. A single, already synchronized and deglitched level input marks a session: while it is high, each pulse from a quarter-second time base advances a 32-bit time count. When the level falls, a 16-bit session count advances by one. Both counts are then saved to a modelled nonvolatile shadow store. When the level rises again, and once after reset, both counts are reloaded from that store before any time is added.

The shadow store keeps the counts in four rotating banks so that wear is spread across them. Each save goes to the next bank in turn and carries a wrapping sequence tag. A load picks the bank whose successor does not continue its tag sequence, which is the bank written most recently. Every save takes a programmable number of clock cycles. A rise of the input while a save is still in progress is held off until the save has finished.

Two programmable limits, each with its own enable, are compared against the counts. When any enabled count has reached or passed its limit, the alarm output is driven to the level chosen by a polarity input. Otherwise the alarm output sits at the opposite level.

Top module: `etr_core`

## Requirements
- R1: After reset the working counts are loaded from the shadow store. With the default store contents of zero, both outputs read 0, and with preset contents they read those values.
- R2: The time count rises by exactly one for each tick_i pulse received while the session input is high and the core has finished loading. Ticks that arrive while the input is low, or on the cycle the input falls, leave it unchanged.
- R3: The time count saturates at 32'hFFFF_FFFF and never wraps to zero.
- R4: Each high-to-low transition of event_i raises the session count by exactly one.
- R5: The session count saturates at 16'hFFFF.
- R6: The counts saved at each falling edge are the counts reloaded at the next rising edge. This holds across more than four saves, so the bank rotation must wrap correctly.
- R7: A rising edge of event_i that arrives while a save is pending does not load or count any time until the save has completed. Ticks in that interval are lost.
- R8: With the time limit enabled, the alarm is active exactly when time_o is greater than or equal to time_limit_i.
- R9: With the session limit enabled, the alarm is active exactly when event_o is greater than or equal to event_limit_i.
- R10: An active alarm drives alarm_o to alarm_pol_i. An inactive alarm, including one with both enables low, drives alarm_o to the inverse of alarm_pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse from the quarter-second time base |
| event_i | input | 1 | Synchronized, deglitched session level |
| time_limit_i | input | 32 | Alarm limit for the time count |
| event_limit_i | input | 16 | Alarm limit for the session count |
| time_alarm_en_i | input | 1 | Enables the time limit comparison |
| event_alarm_en_i | input | 1 | Enables the session limit comparison |
| alarm_pol_i | input | 1 | Level of alarm_o when the alarm is active |
| time_o | output | 32 | Working time count in quarter seconds |
| event_o | output | 16 | Working session count |
| alarm_o | output | 1 | Alarm output |

## Verification
Six sessions are run from a vector table, each with a different number of ticks while high and while low. This separates counting while high from ignoring ticks while low, and the six saves wrap the four-bank rotation so a wrong newest-bank choice shows up on reload. A second instance preset near both maxima pushes the counts into saturation. A fall that is followed at once by a rise, with ticks on the falling cycle and during the pending save, shows whether loads are gated on save completion. The alarm tests step each limit across the current count, one below and equal, for each enable and both polarities.

// File: rtl/etr_pkg.sv
package etr_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LOADW,
        ST_IDLE,
        ST_RUN,
        ST_STORE
    } etr_state_e;
endpackage

// File: rtl/etr_shadow_store.sv
module etr_shadow_store #(
    parameter int TIME_W   = 32,
    parameter int EVT_W    = 16,
    parameter int BANKS    = 4,
    parameter int TAG_W    = 4,
    parameter int WR_DELAY = 8,
    parameter logic [TIME_W-1:0] INIT_TIME = '0,
    parameter logic [EVT_W-1:0]  INIT_EVT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req_i,
    output logic              load_vld_o,
    output logic [TIME_W-1:0] load_time_o,
    output logic [EVT_W-1:0]  load_evt_o,
    input  logic              store_req_i,
    input  logic [TIME_W-1:0] store_time_i,
    input  logic [EVT_W-1:0]  store_evt_i,
    output logic              store_done_o
);
    localparam int PTR_W = $clog2(BANKS);
    localparam int DLY_W = $clog2(WR_DELAY + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BANKS - 1);

    typedef struct packed {
        logic [BANKS-1:0][TIME_W-1:0] b_time;
        logic [BANKS-1:0][EVT_W-1:0]  b_evt;
        logic [BANKS-1:0][TAG_W-1:0]  b_tag;
        logic [PTR_W-1:0]             ptr;
        logic                         busy;
        logic [DLY_W-1:0]             dly;
        logic [TIME_W-1:0]            p_time;
        logic [EVT_W-1:0]             p_evt;
        logic                         rd_vld;
        logic [TIME_W-1:0]            rd_time;
        logic [EVT_W-1:0]             rd_evt;
        logic                         done;
    } store_t;

    store_t q, d;
    logic [PTR_W-1:0] newest;
    logic [PTR_W-1:0] prev;

    always_comb begin
        newest = '0;
        for (int i = 0; i < BANKS; i++) begin
            if (q.b_tag[(i + 1) % BANKS] != TAG_W'(q.b_tag[i] + 1'b1)) begin
                newest = PTR_W'(i);
            end
        end
        prev = (q.ptr == '0) ? LAST : q.ptr - 1'b1;

        d        = q;
        d.rd_vld = 1'b0;
        d.done   = 1'b0;
        if (load_req_i) begin
            d.rd_vld  = 1'b1;
            d.rd_time = q.b_time[newest];
            d.rd_evt  = q.b_evt[newest];
            d.ptr     = (newest == LAST) ? '0 : newest + 1'b1;
        end
        if (store_req_i && !q.busy) begin
            d.busy   = 1'b1;
            d.dly    = DLY_W'(WR_DELAY - 1);
            d.p_time = store_time_i;
            d.p_evt  = store_evt_i;
        end else if (q.busy) begin
            if (q.dly == '0) begin
                d.b_time[q.ptr] = q.p_time;
                d.b_evt[q.ptr]  = q.p_evt;
                d.b_tag[q.ptr]  = q.b_tag[prev] + 1'b1;
                d.ptr           = (q.ptr == LAST) ? '0 : q.ptr + 1'b1;
                d.busy          = 1'b0;
                d.done          = 1'b1;
            end else begin
                d.dly = q.dly - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < BANKS; i++) begin
                q.b_time[i] <= INIT_TIME;
                q.b_evt[i]  <= INIT_EVT;
                q.b_tag[i]  <= TAG_W'(i);
            end
        end else begin
            q <= d;
        end
    end

    assign load_vld_o   = q.rd_vld;
    assign load_time_o  = q.rd_time;
    assign load_evt_o   = q.rd_evt;
    assign store_done_o = q.done;

    // R7: the controller must never ask for a load while a save is pending
    assert_no_load_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_i |-> !q.busy);

    // R6: a completion pulse follows a cycle in which a save was pending
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_done_o |-> $past(q.busy));
endmodule

// File: rtl/etr_ctrl.sv
module etr_ctrl
    import etr_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int EVT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              event_i,
    output logic              load_req_o,
    input  logic              load_vld_i,
    input  logic [TIME_W-1:0] load_time_i,
    input  logic [EVT_W-1:0]  load_evt_i,
    output logic              store_req_o,
    input  logic              store_done_i,
    output logic [TIME_W-1:0] time_o,
    output logic [EVT_W-1:0]  evt_o
);
    typedef struct packed {
        etr_state_e        st;
        logic [TIME_W-1:0] tcnt;
        logic [EVT_W-1:0]  ecnt;
        logic              ld_req;
        logic              st_req;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d        = q;
        d.ld_req = 1'b0;
        d.st_req = 1'b0;
        case (q.st)
            ST_BOOT: begin
                d.ld_req = 1'b1;
                d.st     = ST_LOADW;
            end
            ST_LOADW: begin
                if (load_vld_i) begin
                    d.tcnt = load_time_i;
                    d.ecnt = load_evt_i;
                    d.st   = event_i ? ST_RUN : ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (event_i) begin
                    d.ld_req = 1'b1;
                    d.st     = ST_LOADW;
                end
            end
            ST_RUN: begin
                if (!event_i) begin
                    if (q.ecnt != '1) begin
                        d.ecnt = q.ecnt + 1'b1;
                    end
                    d.st_req = 1'b1;
                    d.st     = ST_STORE;
                end else if (tick_i && (q.tcnt != '1)) begin
                    d.tcnt = q.tcnt + 1'b1;
                end
            end
            ST_STORE: begin
                if (store_done_i) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_BOOT;
        end else begin
            q <= d;
        end
    end

    assign load_req_o  = q.ld_req;
    assign store_req_o = q.st_req;
    assign time_o      = q.tcnt;
    assign evt_o       = q.ecnt;

    // R3: a saturated time count stays saturated while running
    assert_time_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.tcnt == '1) |=> (q.tcnt == '1));

    // R2: while running the time count moves by at most one per cycle
    assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |=> (q.tcnt == $past(q.tcnt) || q.tcnt == $past(q.tcnt) + 1'b1));

    // R2: no time is added while idle with the input low
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |=> $stable(q.tcnt));

    // R4: a fall seen while running changes the session count unless saturated
    assert_event_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !event_i) |=> (q.ecnt != $past(q.ecnt) || q.ecnt == '1));
endmodule

// File: rtl/etr_alarm.sv
module etr_alarm #(
    parameter int TIME_W = 32,
    parameter int EVT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [TIME_W-1:0] time_lim_i,
    input  logic [EVT_W-1:0]  evt_lim_i,
    input  logic              time_en_i,
    input  logic              evt_en_i,
    input  logic              pol_i,
    output logic              alarm_o
);
    typedef struct packed {
        logic active;
    } alm_t;

    alm_t q, d;

    always_comb begin
        d.active = (time_en_i && (time_i >= time_lim_i)) ||
                   (evt_en_i && (evt_i >= evt_lim_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign alarm_o = q.active ? pol_i : !pol_i;

    // R10: with both enables low the pin rests at the inverse polarity
    assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_en_i && !evt_en_i) |=> (alarm_o == !pol_i));

    // R8: an enabled time limit that is reached drives the active level
    assert_time_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (time_en_i && time_i >= time_lim_i) |=> (alarm_o == pol_i));

    // R9: an enabled session limit that is reached drives the active level
    assert_evt_alarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en_i && evt_i >= evt_lim_i) |=> (alarm_o == pol_i));
endmodule

// File: rtl/etr_core.sv
module etr_core #(
    parameter int TIME_W   = 32,
    parameter int EVT_W    = 16,
    parameter int BANKS    = 4,
    parameter int TAG_W    = 4,
    parameter int WR_DELAY = 8,
    parameter logic [TIME_W-1:0] STORE_INIT_TIME = '0,
    parameter logic [EVT_W-1:0]  STORE_INIT_EVT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              event_i,
    input  logic [TIME_W-1:0] time_limit_i,
    input  logic [EVT_W-1:0]  event_limit_i,
    input  logic              time_alarm_en_i,
    input  logic              event_alarm_en_i,
    input  logic              alarm_pol_i,
    output logic [TIME_W-1:0] time_o,
    output logic [EVT_W-1:0]  event_o,
    output logic              alarm_o
);
    logic              load_req;
    logic              load_vld;
    logic [TIME_W-1:0] load_time;
    logic [EVT_W-1:0]  load_evt;
    logic              store_req;
    logic              store_done;

    etr_ctrl #(.TIME_W(TIME_W), .EVT_W(EVT_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .event_i      (event_i),
        .load_req_o   (load_req),
        .load_vld_i   (load_vld),
        .load_time_i  (load_time),
        .load_evt_i   (load_evt),
        .store_req_o  (store_req),
        .store_done_i (store_done),
        .time_o       (time_o),
        .evt_o        (event_o)
    );

    etr_shadow_store #(
        .TIME_W(TIME_W), .EVT_W(EVT_W), .BANKS(BANKS), .TAG_W(TAG_W),
        .WR_DELAY(WR_DELAY), .INIT_TIME(STORE_INIT_TIME), .INIT_EVT(STORE_INIT_EVT)
    ) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_req_i   (load_req),
        .load_vld_o   (load_vld),
        .load_time_o  (load_time),
        .load_evt_o   (load_evt),
        .store_req_i  (store_req),
        .store_time_i (time_o),
        .store_evt_i  (event_o),
        .store_done_o (store_done)
    );

    etr_alarm #(.TIME_W(TIME_W), .EVT_W(EVT_W)) alarm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_i     (time_o),
        .evt_i      (event_o),
        .time_lim_i (time_limit_i),
        .evt_lim_i  (event_limit_i),
        .time_en_i  (time_alarm_en_i),
        .evt_en_i   (event_alarm_en_i),
        .pol_i      (alarm_pol_i),
        .alarm_o    (alarm_o)
    );
endmodule

// File: tb/etr_core_tb_top.sv
module etr_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ev = 1'b0;
    logic        tick2 = 1'b0;
    logic        ev2 = 1'b0;
    logic [31:0] tlim = '0;
    logic [15:0] elim = '0;
    logic        ten = 1'b0;
    logic        een = 1'b0;
    logic        pol = 1'b1;
    logic [31:0] t_o, t2_o;
    logic [15:0] e_o, e2_o;
    logic        alm, alm2;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    etr_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .event_i(ev),
        .time_limit_i(tlim), .event_limit_i(elim),
        .time_alarm_en_i(ten), .event_alarm_en_i(een), .alarm_pol_i(pol),
        .time_o(t_o), .event_o(e_o), .alarm_o(alm)
    );

    etr_core #(.STORE_INIT_TIME(32'hFFFF_FFFD), .STORE_INIT_EVT(16'hFFFF)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick2), .event_i(ev2),
        .time_limit_i(32'd0), .event_limit_i(16'd0),
        .time_alarm_en_i(1'b0), .event_alarm_en_i(1'b0), .alarm_pol_i(1'b0),
        .time_o(t2_o), .event_o(e2_o), .alarm_o(alm2)
    );

    typedef struct packed {
        logic [7:0]  hi_ticks;
        logic [7:0]  lo_ticks;
        logic [31:0] exp_time;
        logic [15:0] exp_evt;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{8'd3, 8'd2, 32'd3,  16'd1},
        '{8'd0, 8'd4, 32'd3,  16'd2},
        '{8'd5, 8'd0, 32'd8,  16'd3},
        '{8'd1, 8'd1, 32'd9,  16'd4},
        '{8'd7, 8'd3, 32'd16, 16'd5},
        '{8'd2, 8'd0, 32'd18, 16'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic ticks2(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick2 = 1'b1;
            @(negedge clk) tick2 = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(6);
        // R1: reset load from default store
        check("R1 time after reset", t_o, 32'd0);
        check("R1 events after reset", {16'd0, e_o}, 32'd0);
        check("R10 idle alarm level", {31'd0, alm}, 32'd0);
        check("R1 preset time after reset", t2_o, 32'hFFFF_FFFD);

        // table of sessions, six saves wrap the four banks
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk) ev = 1'b1;
            wait_cyc(6);
            if (r > 0) begin
                check("R6 reloaded time", t_o, ROWS[r-1].exp_time);
                check("R6 reloaded events", {16'd0, e_o}, {16'd0, ROWS[r-1].exp_evt});
            end
            ticks(int'(ROWS[r].hi_ticks));
            wait_cyc(2);
            check("R2 time while high", t_o, ROWS[r].exp_time);
            @(negedge clk) ev = 1'b0;
            wait_cyc(25);
            ticks(int'(ROWS[r].lo_ticks));
            wait_cyc(2);
            check("R2 ticks ignored while low", t_o, ROWS[r].exp_time);
            check("R4 event count after fall", {16'd0, e_o}, {16'd0, ROWS[r].exp_evt});
        end

        // R7 and R4: fall with a tick on the same cycle, rise during pending save
        @(negedge clk) ev = 1'b1;
        wait_cyc(6);
        ticks(2);
        @(negedge clk) begin ev = 1'b0; tick = 1'b1; end
        @(negedge clk) begin ev = 1'b1; tick = 1'b0; end
        ticks(3);
        wait_cyc(30);
        check("R7 ticks during pending save lost", t_o, 32'd20);
        check("R4 single increment on fall", {16'd0, e_o}, 32'd7);
        ticks(1);
        wait_cyc(2);
        check("R7 counting resumes after load", t_o, 32'd21);
        @(negedge clk) ev = 1'b0;
        wait_cyc(25);
        check("R4 event count after second fall", {16'd0, e_o}, 32'd8);

        // alarm checks: time 21, events 8
        tlim = 32'd21; ten = 1'b1; pol = 1'b1;
        wait_cyc(3);
        check("R8 time equal to limit", {31'd0, alm}, 32'd1);
        tlim = 32'd22;
        wait_cyc(3);
        check("R8 time below limit", {31'd0, alm}, 32'd0);
        ten = 1'b0; een = 1'b1; elim = 16'd8;
        wait_cyc(3);
        check("R9 events equal to limit", {31'd0, alm}, 32'd1);
        elim = 16'd9;
        wait_cyc(3);
        check("R9 events below limit", {31'd0, alm}, 32'd0);
        pol = 1'b0;
        wait_cyc(3);
        check("R10 inactive low polarity", {31'd0, alm}, 32'd1);
        elim = 16'd3;
        wait_cyc(3);
        check("R10 active low polarity", {31'd0, alm}, 32'd0);
        een = 1'b0; tlim = 32'd0;
        wait_cyc(3);
        check("R10 disabled limits inactive", {31'd0, alm}, 32'd1);

        // saturation instance
        @(negedge clk) ev2 = 1'b1;
        wait_cyc(6);
        ticks2(5);
        wait_cyc(2);
        check("R3 time saturates", t2_o, 32'hFFFF_FFFF);
        @(negedge clk) ev2 = 1'b0;
        wait_cyc(25);
        check("R5 events saturate", {16'd0, e2_o}, 32'h0000_FFFF);
        @(negedge clk) ev2 = 1'b1;
        wait_cyc(6);
        check("R6 saturated time reloaded", t2_o, 32'hFFFF_FFFF);
        check("R5 saturated events reloaded", {16'd0, e2_o}, 32'h0000_FFFF);

        finish_run();
    end
endmodule